// File: doc/BRIEF.md
# Scanout Pixel Address Generator

This block produces the byte address of each pixel that the display fetch path reads during active scanout. It assembles a 20-bit display start value from fields that sit in four separate control registers. It forms a line pitch from an offset register and one extension bit. It then walks the frame memory in step with three strobes from the display timing generator.

A frame-start strobe reloads the address from the start value. The start value counts 4-byte units, so it is scaled by four. A line-start strobe moves the line base forward by one pitch. Each pixel-advance strobe moves the address forward by the pixel size that the depth-mode register selects. Memory arbitration and pixel unpacking belong to downstream logic.

The register inputs are expected to stay steady while a frame is being scanned. Software reprograms them between frames.

Top module: `scan_addr_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pix_addr` becomes 0 and `depth_err` becomes 0.
- R2: The start value S is assembled as follows: S[7:0] = `crt_start_lo`, S[15:8] = `crt_start_hi`, S[16] = `crt_ext_a[0]`, S[18:17] = `crt_ext_a[3:2]`, S[19] = `crt_ext_b[7]`. A `frame_start` pulse sets `pix_addr` to S×4 on the next edge, and this value also becomes the line base.
- R3: The pitch P in 8-byte units is {`crt_ext_a[4]`, `crt_pitch`}, a 9-bit value. A `line_start` pulse without `frame_start` sets both the line base and `pix_addr` to the previous line base plus P×8.
- R4: Bits 4:0 of `seq_depth` select the pixel size: 0x11 gives 1 byte, 0x17 gives 2, 0x15 gives 3 and 0x19 gives 4. Bits 7:5 are ignored. A lone `pix_adv` pulse adds that size to `pix_addr`.
- R5: For any other value of `seq_depth[4:0]`, a lone `pix_adv` pulse leaves `pix_addr` unchanged. In that case `depth_err` is 1 on the edge after the code is present; otherwise it is 0.
- R6: When strobes coincide, `frame_start` wins over `line_start`, and `line_start` wins over `pix_adv`.
- R7: With no strobe asserted, `pix_addr` holds its value.
- R8: Every address sum wraps modulo 2^ADDR_W (22 bits by default).
- R9: The bits of `crt_ext_a` (7:5 and 1) and of `crt_ext_b` (6:0) that are not named in R2 or R3 have no effect on any address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Synchronous reset, active low |
| crt_start_hi | input | 8 | Start value bits 15:8 |
| crt_start_lo | input | 8 | Start value bits 7:0 |
| crt_ext_a | input | 8 | Extension register: start bits 16, 18:17 and pitch bit 8 |
| crt_ext_b | input | 8 | Extension register: start bit 19 in bit 7 |
| crt_pitch | input | 8 | Line pitch bits 7:0, in 8-byte units |
| seq_depth | input | 8 | Packed-pixel depth-mode code |
| frame_start | input | 1 | First-line strobe from the timing generator |
| line_start | input | 1 | Next-line strobe |
| pix_adv | input | 1 | Pixel-advance strobe |
| pix_addr | output | ADDR_W | Byte address of the current pixel |
| depth_err | output | 1 | Registered flag: depth code not recognized |

## Verification
The assertions assume that every register input and strobe is at a defined value from the first clock edge, and that all strobes are low while reset is asserted. They also assume each register input is stable across the edge that consumes it. The bench drives all inputs at falling edges only and holds the strobes low through reset. It changes register values only between frames. It sweeps every valid depth code, start values up to the 20-bit maximum and pitch values that use the extension bit. Junk is placed in every ignored register bit.

// File: rtl/scan_addr_pkg.sv
// Package: shared widths and the depth-mode code points of the scanout
// address generator. Assumes 8-bit control registers.
package scan_addr_pkg;
    localparam int REG_W      = 8;
    localparam int START_W    = 20;   // start value width, 4-byte units
    localparam int PITCH_W    = 9;    // pitch width, 8-byte units
    localparam int STEP_W     = 3;    // pixel size in bytes, 1..4

    localparam logic [4:0] DEPTH_8BPP  = 5'h11;
    localparam logic [4:0] DEPTH_16BPP = 5'h17;
    localparam logic [4:0] DEPTH_24BPP = 5'h15;
    localparam logic [4:0] DEPTH_32BPP = 5'h19;

    typedef logic [STEP_W-1:0] step_t;
endpackage

// File: rtl/scan_start_assemble.sv
// Module: gathers the scattered start-address and pitch fields into
// byte-scaled values. Purely combinational; assumes ADDR_W >= 22.
module scan_start_assemble
    import scan_addr_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic [REG_W-1:0]  start_hi,
    input  logic [REG_W-1:0]  start_lo,
    input  logic [REG_W-1:0]  ext_a,
    input  logic [REG_W-1:0]  ext_b,
    input  logic [REG_W-1:0]  pitch_lo,
    output logic [ADDR_W-1:0] start_bytes,
    output logic [ADDR_W-1:0] pitch_bytes
);
    logic [START_W-1:0] start_units;
    logic [PITCH_W-1:0] pitch_units;

    // Concatenate the start fields and scale by four.
    always_comb begin
        start_units = {ext_b[7], ext_a[3:2], ext_a[0], start_hi, start_lo};
        start_bytes = ADDR_W'({start_units, 2'b00});
    end

    // Concatenate the pitch fields and scale by eight.
    always_comb begin
        pitch_units = {ext_a[4], pitch_lo};
        pitch_bytes = ADDR_W'({pitch_units, 3'b000});
    end
endmodule

// File: rtl/scan_depth_decode.sv
// Module: maps the packed-pixel depth code to a byte step per pixel.
// Only the low five bits take part; an unknown code gives valid = 0.
module scan_depth_decode
    import scan_addr_pkg::*;
(
    input  logic [REG_W-1:0] depth_code,
    output step_t            step,
    output logic             valid
);
    // Decode the code point into a pixel size.
    always_comb begin
        valid = 1'b1;
        unique case (depth_code[4:0])
            DEPTH_8BPP:  step = 3'd1;
            DEPTH_16BPP: step = 3'd2;
            DEPTH_24BPP: step = 3'd3;
            DEPTH_32BPP: step = 3'd4;
            default: begin
                step  = 3'd0;
                valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/scan_addr_accum.sv
// Module: line-base and pixel address registers. Priority is frame,
// then line, then pixel. Sums wrap at ADDR_W bits. Synchronous active-low reset.
module scan_addr_accum
    import scan_addr_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_bytes,
    input  logic [ADDR_W-1:0] pitch_bytes,
    input  step_t             step,
    input  logic              step_ok,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              pix_adv,
    output logic [ADDR_W-1:0] line_base,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] next_line;
    logic [ADDR_W-1:0] next_pix;

    // Candidate sums for the next line and the next pixel.
    always_comb begin
        next_line = line_base + pitch_bytes;
        next_pix  = addr + ADDR_W'(step);
    end

    // Update the line base and pixel address by strobe priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_base <= '0;
            addr      <= '0;
        end else if (frame_start) begin
            line_base <= start_bytes;
            addr      <= start_bytes;
        end else if (line_start) begin
            line_base <= next_line;
            addr      <= next_line;
        end else if (pix_adv && step_ok) begin
            addr      <= next_pix;
        end
    end
endmodule

// File: rtl/scan_addr_gen.sv
// Module: top of the scanout pixel address generator. It joins the field
// assembler, the depth decoder and the address accumulator, and registers
// the depth error flag. Assumes register inputs are steady during a frame.
module scan_addr_gen
    import scan_addr_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        crt_start_hi,
    input  logic [7:0]        crt_start_lo,
    input  logic [7:0]        crt_ext_a,
    input  logic [7:0]        crt_ext_b,
    input  logic [7:0]        crt_pitch,
    input  logic [7:0]        seq_depth,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              pix_adv,
    output logic [ADDR_W-1:0] pix_addr,
    output logic              depth_err
);
    logic [ADDR_W-1:0] start_bytes;
    logic [ADDR_W-1:0] pitch_bytes;
    logic [ADDR_W-1:0] line_base_q;
    step_t             step;
    logic              step_ok;

    scan_start_assemble #(.ADDR_W(ADDR_W)) asm_i (
        .start_hi   (crt_start_hi),
        .start_lo   (crt_start_lo),
        .ext_a      (crt_ext_a),
        .ext_b      (crt_ext_b),
        .pitch_lo   (crt_pitch),
        .start_bytes(start_bytes),
        .pitch_bytes(pitch_bytes)
    );

    scan_depth_decode dec_i (
        .depth_code(seq_depth),
        .step      (step),
        .valid     (step_ok)
    );

    scan_addr_accum #(.ADDR_W(ADDR_W)) acc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_bytes(start_bytes),
        .pitch_bytes(pitch_bytes),
        .step       (step),
        .step_ok    (step_ok),
        .frame_start(frame_start),
        .line_start (line_start),
        .pix_adv    (pix_adv),
        .line_base  (line_base_q),
        .addr       (pix_addr)
    );

    // Register the error flag for an unrecognized depth code.
    always_ff @(posedge clk) begin
        if (!rst_n) depth_err <= 1'b0;
        else        depth_err <= !step_ok;
    end
endmodule

// File: rtl/scan_addr_gen_chk.sv
// Checker: temporal properties of the scanout address generator, computed
// from its ports and its line-base register. Attached by bind below.
module scan_addr_gen_chk #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        crt_start_hi,
    input logic [7:0]        crt_start_lo,
    input logic [7:0]        crt_ext_a,
    input logic [7:0]        crt_ext_b,
    input logic [7:0]        crt_pitch,
    input logic [7:0]        seq_depth,
    input logic              frame_start,
    input logic              line_start,
    input logic              pix_adv,
    input logic [ADDR_W-1:0] pix_addr,
    input logic              depth_err,
    input logic [ADDR_W-1:0] line_base_q
);
    logic [ADDR_W-1:0] exp_start;
    logic [ADDR_W-1:0] exp_pitch;
    logic [2:0]        exp_step;
    logic              known;

    // Reference start, pitch and step, derived from the ports.
    always_comb begin
        exp_start = ADDR_W'({crt_ext_b[7], crt_ext_a[3], crt_ext_a[2], crt_ext_a[0],
                             crt_start_hi, crt_start_lo}) * ADDR_W'(4);
        exp_pitch = ADDR_W'({crt_ext_a[4], crt_pitch}) * ADDR_W'(8);
        known     = 1'b1;
        case (seq_depth[4:0])
            5'h11:   exp_step = 3'd1;
            5'h17:   exp_step = 3'd2;
            5'h15:   exp_step = 3'd3;
            5'h19:   exp_step = 3'd4;
            default: begin exp_step = 3'd0; known = 1'b0; end
        endcase
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pix_addr == '0 && !depth_err));

    // R2
    frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> pix_addr == $past(exp_start));

    // R3
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !frame_start) |=>
            pix_addr == $past(line_base_q) + $past(exp_pitch));

    // R4
    pixel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_adv && !line_start && !frame_start && known) |=>
            pix_addr == $past(pix_addr) + ADDR_W'($past(exp_step)));

    // R5
    bad_depth_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_adv && !line_start && !frame_start && !known) |=> $stable(pix_addr));

    // R5
    depth_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> depth_err == !$past(known));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_adv && !line_start && !frame_start) |=> $stable(pix_addr));
endmodule

bind scan_addr_gen scan_addr_gen_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .crt_start_hi(crt_start_hi),
    .crt_start_lo(crt_start_lo),
    .crt_ext_a   (crt_ext_a),
    .crt_ext_b   (crt_ext_b),
    .crt_pitch   (crt_pitch),
    .seq_depth   (seq_depth),
    .frame_start (frame_start),
    .line_start  (line_start),
    .pix_adv     (pix_adv),
    .pix_addr    (pix_addr),
    .depth_err   (depth_err),
    .line_base_q (line_base_q)
);

// File: tb/scan_addr_gen_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps depth codes, start values and pitches over short frames
// and compares every address with an arithmetic model.
module scan_addr_gen_tb_top;
    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    start_hi = 8'h0, start_lo = 8'h0, ext_a = 8'h0, ext_b = 8'h0;
    logic [7:0]    pitch = 8'h0, depth = 8'h11;
    logic          fs = 1'b0, ls = 1'b0, pa = 1'b0;
    logic [AW-1:0] pix_addr;
    logic          depth_err;

    int checks = 0;
    int errors = 0;
    logic [AW-1:0] m_base, m_addr, m_start, m_pitch;

    always #4 clk = ~clk;

    scan_addr_gen #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .crt_start_hi(start_hi), .crt_start_lo(start_lo),
        .crt_ext_a(ext_a), .crt_ext_b(ext_b), .crt_pitch(pitch),
        .seq_depth(depth), .frame_start(fs), .line_start(ls), .pix_adv(pa),
        .pix_addr(pix_addr), .depth_err(depth_err)
    );

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int step_of(input logic [7:0] d);
        case (d[4:0])
            5'h11: return 1;
            5'h17: return 2;
            5'h15: return 3;
            5'h19: return 4;
            default: return 0;
        endcase
    endfunction

    // Program registers; junk fills the bits that must be ignored (R9).
    task automatic set_regs(input logic [19:0] s, input logic [8:0] p,
                            input logic [7:0] d, input logic [7:0] junk);
        @(negedge clk);
        start_lo = s[7:0];
        start_hi = s[15:8];
        ext_a    = {junk[3:1], p[8], s[18:17], junk[0], s[16]};
        ext_b    = {s[19], junk[6:0]};
        pitch    = p[7:0];
        depth    = d;
        m_start  = AW'(s) * AW'(4);
        m_pitch  = AW'(p) * AW'(8);
    endtask

    // Pulse the strobes for one edge, update the model, then check.
    task automatic strobe(input logic f, input logic l, input logic a, input string tag);
        @(negedge clk);
        fs = f; ls = l; pa = a;
        if (f) begin m_base = m_start; m_addr = m_start; end
        else if (l) begin m_base = m_base + m_pitch; m_addr = m_base; end
        else if (a) m_addr = m_addr + AW'(step_of(depth));
        @(negedge clk);
        fs = 1'b0; ls = 1'b0; pa = 1'b0;
        chk(tag, pix_addr, m_addr);
        chk("R5 depth_err", AW'(depth_err), AW'(step_of(depth) == 0));
    endtask

    initial begin
        #1600000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [19:0] starts [4];
        logic [8:0]  pitches [3];
        logic [7:0]  depths [5];
        starts  = '{20'h00000, 20'h12345, 20'hA5F0C, 20'hFFFFF};
        pitches = '{9'h000, 9'h0F0, 9'h1FF};
        depths  = '{8'h11, 8'h17, 8'h15, 8'h19, 8'hF9};
        m_base = '0; m_addr = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset addr", pix_addr, '0);
        chk("R1 reset err", AW'(depth_err), '0);
        rst_n = 1'b1;

        // R2 R3 R4 R8 R9: sweep start, pitch and depth over three lines.
        foreach (depths[di]) begin
            foreach (starts[si]) begin
                foreach (pitches[pi]) begin
                    set_regs(starts[si], pitches[pi], depths[di], 8'(si * 37 + pi * 11 + di));
                    strobe(1, 0, 0, "R2 frame load");
                    for (int ln = 0; ln < 3; ln++) begin
                        for (int px = 0; px < 4; px++) strobe(0, 0, 1, "R4 pixel step");
                        // R7: idle cycle holds
                        strobe(0, 0, 0, "R7 idle hold");
                        strobe(0, 1, 0, "R3 line step / R8 wrap");
                    end
                end
            end
        end

        // R5: unknown depth codes freeze the address.
        set_regs(20'h00100, 9'h010, 8'h10, 8'h00);
        strobe(1, 0, 0, "R2 frame load");
        strobe(0, 0, 1, "R5 hold on code 10");
        set_regs(20'h00100, 9'h010, 8'h00, 8'h00);
        strobe(0, 0, 1, "R5 hold on code 00");
        set_regs(20'h00100, 9'h010, 8'h1F, 8'hFF);
        strobe(0, 0, 1, "R5 hold on code 1F");

        // R6: coinciding strobes follow priority.
        set_regs(20'h00200, 9'h004, 8'h19, 8'h55);
        strobe(1, 0, 0, "R6 setup");
        strobe(0, 0, 1, "R6 setup pixel");
        strobe(1, 1, 1, "R6 frame wins");
        strobe(0, 0, 1, "R6 setup pixel");
        strobe(0, 1, 1, "R6 line wins");
        strobe(1, 1, 0, "R6 frame over line");

        // R1: reset mid-run clears the address.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset again", pix_addr, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule